// File: doc/BRIEF.md
# Selectable-Order Sinc Decimator for a 1-Bit Density Stream

This block turns a one-bit pulse-density stream into signed 24-bit samples. It uses a cascade of integrators running at the input rate, followed by a cascade of differentiators running at the output rate. The number of stages (1 to 5) and the rate reduction (a power of two) are picked from coded configuration fields. Each accepted input bit counts as +1 when high and -1 when low. One copy is placed per microphone channel, and its input bit is qualified by a valid strobe.

Two field sets choose the rate reduction. In the direct path, a 4-bit code gives a reduction from 8 to 256. In the audio path, a 2-bit code gives 64, 128 or 256 overall. The configuration is captured once, when capture starts, and is held for the whole capture. The first few results after a start are dropped while the differentiator history fills. Each kept result is scaled so that a full-density stream lands on the 24-bit full scale, and positive full scale is clamped.

Top module: `cic_decim`

## Requirements
- R1: After reset, `pcm_valid` is 0 and `pcm_data` is 0. The held stage count is 3 and no rate is held, so no sample is produced until a capture is started with a legal rate.
- R2: An accepted bit (`pdm_valid`=1 during capture) counts as +1 if 1 and -1 if 0. Let N be the stage count, R the rate and x[n] the n-th accepted value of the capture. Each R-th accepted bit ends a window, and `pcm_valid` pulses in the cycle after the clock edge that accepts that bit. `pcm_data` is then floor(y·2^23 / R^N), where y = Σ h[j]·x[n−j] and h is the box of R ones convolved with itself N times.
- R3: `order_sel` (4 bits) gives the stage count for values 1 to 5. Any other value selects 3 stages.
- R4: With `filt_sel`=0, `sinc_rate_sel` code c in 1..6 gives R = 2^(c+2), so 1→8 and 6→256. Codes 0 and 7..15 produce no output.
- R5: With `filt_sel`=1, `af_rate_sel` code c in 1..3 gives R = 2^(c+5), so 64, 128 or 256. Code 0 produces no output. The stage count from `order_sel` still applies.
- R6: The configuration inputs are sampled at the first clock edge where `capture_en` is high. Changes while `capture_en` stays high have no effect on the output.
- R7: A capture start clears all filter state. The first N window ends of a capture produce no `pcm_valid`.
- R8: Cycles with `pdm_valid`=0, and any cycle while `capture_en` is low, change nothing and give no output.
- R9: Results above 2^23−1 are clamped to 0x7FFFFF. An all-ones stream gives 0x7FFFFF and an all-zeros stream gives 0x800000.
- R10: `pcm_valid` is a single-cycle pulse and never high two cycles in a row. It is low in the cycle after the first cycle in which `capture_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Working clock |
| rst_n | input | 1 | Active-low reset |
| capture_en | input | 1 | Capture active; rising edge loads configuration |
| filt_sel | input | 1 | 0 direct path, 1 audio path |
| order_sel | input | 4 | Stage count code |
| sinc_rate_sel | input | 4 | Direct-path rate code |
| af_rate_sel | input | 2 | Audio-path rate code |
| pdm_valid | input | 1 | Input bit qualifier |
| pdm_bit | input | 1 | Density bit |
| pcm_data | output | 24 | Signed sample |
| pcm_valid | output | 1 | Sample strobe |

## Verification
The bench builds the block with its default constants: up to five stages and reductions up to 256. Rate 8 lets every stage count from 1 to 5 reach many checked windows within a few hundred bits. A pseudo-random stream exercises the non-constant weighting of the window, and frequent idle cycles test the input qualifier. Rate 256 with five stages drives the widest shift and the 42-bit accumulator to its extreme, which brings the clamp and the exact negative full scale within reach.

// File: rtl/cic_decim_pkg.sv
package cic_decim_pkg;
    localparam int MAX_ORDER = 5;
    localparam int MAX_LOG2R = 8;
    localparam int OUT_W     = 24;
    localparam int ORD_W     = 3;
    localparam int LR_W      = 4;
    localparam int ACC_W     = 2 + MAX_ORDER * MAX_LOG2R;
    localparam logic [ORD_W-1:0] DEF_ORDER = ORD_W'(3);

    typedef struct packed {
        logic [ORD_W-1:0] order;
        logic [LR_W-1:0]  log2r;
        logic             rate_ok;
    } cic_cfg_t;

    function automatic cic_cfg_t decode_cfg(input logic       fsel,
                                            input logic [3:0] ord,
                                            input logic [3:0] srate,
                                            input logic [1:0] arate);
        cic_cfg_t c;
        if (ord >= 4'd1 && ord <= 4'(MAX_ORDER)) c.order = ord[ORD_W-1:0];
        else                                     c.order = DEF_ORDER;
        if (fsel) begin
            c.rate_ok = (arate != 2'd0);
            c.log2r   = LR_W'(arate) + LR_W'(5);
        end else begin
            c.rate_ok = (srate >= 4'd1) && (srate <= 4'd6);
            c.log2r   = srate + LR_W'(2);
        end
        return c;
    endfunction
endpackage

// File: rtl/cic_cfg_hold.sv
module cic_cfg_hold
    import cic_decim_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture_en,
    input  logic       filt_sel,
    input  logic [3:0] order_sel,
    input  logic [3:0] sinc_rate_sel,
    input  logic [1:0] af_rate_sel,
    output cic_cfg_t   cfg,
    output logic       start,
    output logic       run
);
    typedef struct packed {
        cic_cfg_t cfg;
        logic     en_prev;
    } hold_t;

    hold_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        start = capture_en & ~s_q.en_prev;
        if (start) s_d.cfg = decode_cfg(filt_sel, order_sel, sinc_rate_sel, af_rate_sel);
        s_d.en_prev = capture_en;
        run   = capture_en & s_q.en_prev & s_q.cfg.rate_ok;
        cfg   = s_q.cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cfg.order   <= DEF_ORDER;
            s_q.cfg.log2r   <= '0;
            s_q.cfg.rate_ok <= 1'b0;
            s_q.en_prev     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/cic_integ_bank.sv
module cic_integ_bank
    import cic_decim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             bit_in,
    input  logic [ORD_W-1:0] order,
    output logic [ACC_W-1:0] tap
);
    typedef struct packed {
        logic [MAX_ORDER-1:0][ACC_W-1:0] acc;
    } integ_t;

    integ_t s_d, s_q;
    logic [ACC_W-1:0] nxt [MAX_ORDER];
    logic [ACC_W-1:0] x_val;

    always_comb begin
        x_val  = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};
        nxt[0] = s_q.acc[0] + x_val;
        for (int k = 1; k < MAX_ORDER; k++) nxt[k] = s_q.acc[k] + nxt[k-1];
        tap = nxt[0];
        for (int k = 0; k < MAX_ORDER; k++)
            if (order == ORD_W'(k + 1)) tap = nxt[k];
        s_d = s_q;
        if (clear) s_d = '0;
        else if (step)
            for (int k = 0; k < MAX_ORDER; k++) s_d.acc[k] = nxt[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/cic_comb_out.sv
module cic_comb_out
    import cic_decim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [ORD_W-1:0] order,
    input  logic [LR_W-1:0]  log2r,
    input  logic [ACC_W-1:0] tap,
    output logic [OUT_W-1:0] pcm_data,
    output logic             pcm_valid
);
    localparam int PH_W   = MAX_LOG2R;
    localparam int WIDE_W = ACC_W + OUT_W;
    localparam int TOPB   = OUT_W - 1;
    localparam logic signed [WIDE_W-1:0] LIM_POS = WIDE_W'((64'sd1 <<< TOPB) - 64'sd1);

    typedef struct packed {
        logic [PH_W-1:0]                 phase;
        logic [ORD_W-1:0]                skip;
        logic [MAX_ORDER-1:0][ACC_W-1:0] dly;
        logic [OUT_W-1:0]                out;
        logic                            vld;
    } comb_t;

    comb_t s_d, s_q;
    logic [ACC_W-1:0]         diff [MAX_ORDER];
    logic [ACC_W-1:0]         y;
    logic [PH_W:0]            one_sh;
    logic [PH_W-1:0]          lim;
    logic                     last;
    logic [5:0]               sh;
    logic signed [WIDE_W-1:0] ext, sc;

    always_comb begin
        one_sh = (PH_W+1)'(1) << log2r;
        lim    = PH_W'(one_sh - (PH_W+1)'(1));
        last   = (s_q.phase == lim);

        diff[0] = tap - s_q.dly[0];
        for (int k = 1; k < MAX_ORDER; k++) diff[k] = diff[k-1] - s_q.dly[k];
        y = diff[0];
        for (int k = 0; k < MAX_ORDER; k++)
            if (order == ORD_W'(k + 1)) y = diff[k];

        sh  = 6'(order) * 6'(log2r);
        ext = WIDE_W'($signed(y));
        if (sh <= 6'(TOPB)) sc = ext <<< (6'(TOPB) - sh);
        else                sc = ext >>> (sh - 6'(TOPB));

        s_d     = s_q;
        s_d.vld = 1'b0;
        if (clear) begin
            s_d = '0;
        end else if (step) begin
            s_d.phase = last ? '0 : s_q.phase + PH_W'(1);
            if (last) begin
                s_d.dly[0] = tap;
                for (int k = 1; k < MAX_ORDER; k++) s_d.dly[k] = diff[k-1];
                if (s_q.skip < order) begin
                    s_d.skip = s_q.skip + ORD_W'(1);
                end else begin
                    s_d.vld = 1'b1;
                    s_d.out = (sc > LIM_POS) ? LIM_POS[OUT_W-1:0] : sc[OUT_W-1:0];
                end
            end
        end
        pcm_data  = s_q.out;
        pcm_valid = s_q.vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/cic_decim.sv
module cic_decim
    import cic_decim_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        capture_en,
    input  logic        filt_sel,
    input  logic [3:0]  order_sel,
    input  logic [3:0]  sinc_rate_sel,
    input  logic [1:0]  af_rate_sel,
    input  logic        pdm_valid,
    input  logic        pdm_bit,
    output logic [23:0] pcm_data,
    output logic        pcm_valid
);
    cic_cfg_t         cfg_w;
    logic             start_w, run_w, step_w;
    logic [ACC_W-1:0] tap_w;

    assign step_w = run_w & pdm_valid;

    cic_cfg_hold u_cfg (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .filt_sel(filt_sel),
        .order_sel(order_sel), .sinc_rate_sel(sinc_rate_sel), .af_rate_sel(af_rate_sel),
        .cfg(cfg_w), .start(start_w), .run(run_w)
    );

    cic_integ_bank u_int (
        .clk(clk), .rst_n(rst_n), .clear(start_w), .step(step_w),
        .bit_in(pdm_bit), .order(cfg_w.order), .tap(tap_w)
    );

    cic_comb_out u_cmb (
        .clk(clk), .rst_n(rst_n), .clear(start_w), .step(step_w),
        .order(cfg_w.order), .log2r(cfg_w.log2r), .tap(tap_w),
        .pcm_data(pcm_data), .pcm_valid(pcm_valid)
    );
endmodule

// File: rtl/cic_decim_chk.sv
module cic_decim_chk
    import cic_decim_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     capture_en,
    input logic     pcm_valid,
    input cic_cfg_t cfg
);
    assert_valid_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |=> !pcm_valid);

    assert_stop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(capture_en) |=> !pcm_valid);

    assert_valid_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |-> $past(capture_en));

    assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && $past(capture_en) && $past(capture_en, 2)) |-> $stable(cfg));

    assert_order_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.order >= ORD_W'(1)) && (cfg.order <= ORD_W'(MAX_ORDER)));
endmodule

bind cic_decim cic_decim_chk u_chk (
    .clk(clk), .rst_n(rst_n), .capture_en(capture_en),
    .pcm_valid(pcm_valid), .cfg(cfg_w)
);

// File: tb/cic_decim_test.sv
module cic_decim_test;
    localparam int CLK_PERIOD = 10;
    localparam int HMAX = 1400;
    localparam int XMAX = 2100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        capture_en = 1'b0;
    logic        filt_sel = 1'b0;
    logic [3:0]  order_sel = 4'd3;
    logic [3:0]  sinc_rate_sel = 4'd1;
    logic [1:0]  af_rate_sel = 2'd1;
    logic        pdm_valid = 1'b0;
    logic        pdm_bit = 1'b0;
    logic [23:0] pcm_data;
    logic        pcm_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [15:0] lfsr = 16'hACE1;
    longint h [HMAX];
    longint tmp [HMAX];
    int hx [XMAX];
    int hlen;

    always #(CLK_PERIOD/2) clk = ~clk;

    cic_decim uut (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .filt_sel(filt_sel),
        .order_sel(order_sel), .sinc_rate_sel(sinc_rate_sel), .af_rate_sel(af_rate_sel),
        .pdm_valid(pdm_valid), .pdm_bit(pdm_bit), .pcm_data(pcm_data), .pcm_valid(pcm_valid)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic b);
        @(negedge clk);
        pdm_valid = v;
        pdm_bit   = b;
        @(posedge clk);
        #1;
    endtask

    task automatic build_h(input int n, input int r);
        h[0] = 1;
        hlen = 1;
        for (int s = 0; s < n; s++) begin
            for (int i = 0; i < hlen + r - 1; i++) begin
                tmp[i] = 0;
                for (int j = 0; j < r; j++)
                    if (i - j >= 0 && i - j < hlen) tmp[i] += h[i-j];
            end
            hlen = hlen + r - 1;
            for (int i = 0; i < hlen; i++) h[i] = tmp[i];
        end
    endtask

    function automatic logic [23:0] expect_at(input int n, input int nn, input int lr);
        longint y, v, d;
        int s;
        y = 0;
        for (int j = 0; j < hlen; j++)
            if (n - j >= 0) y += h[j] * longint'(hx[n-j]);
        s = nn * lr;
        if (s <= 23) v = y * (64'sd1 <<< (23 - s));
        else begin
            d = 64'sd1 <<< (s - 23);
            v = y / d;
            if ((y % d) != 0 && y < 0) v = v - 1;
        end
        if (v > 64'sd8388607) v = 64'sd8388607;
        return v[23:0];
    endfunction

    function automatic logic gen_bit(input int kind, input int n);
        case (kind)
            1: return 1'b1;
            2: return 1'b0;
            3: return (n % 4) == 0;
            default: return lfsr[0];
        endcase
    endfunction

    task automatic run_case(input logic fsel, input logic [3:0] ordf, input logic [3:0] sratef,
                            input logic [1:0] aratef, input int effn, input int lr, input bit ok,
                            input int nsmp, input int kind, input bit mid, input string tag);
        int r;
        int m;
        logic b;
        r = 1 << lr;
        @(negedge clk);
        capture_en = 1'b0;
        pdm_valid  = 1'b0;
        @(negedge clk);
        filt_sel = fsel; order_sel = ordf; sinc_rate_sel = sratef; af_rate_sel = aratef;
        @(negedge clk);
        capture_en = 1'b1;
        @(posedge clk);
        #1;
        if (ok) build_h(effn, r);
        for (int n = 0; n < nsmp; n++) begin
            if (n % 7 == 3) begin
                step(1'b0, ~pdm_bit);
                if (pcm_valid) chk(1'b0, {tag, " R8 idle cycle output"}, 1, 0);
            end
            if (mid && n == nsmp / 2) begin
                order_sel = 4'd1; sinc_rate_sel = 4'd6; filt_sel = 1'b1; af_rate_sel = 2'd3;
            end
            b = gen_bit(kind, n);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            hx[n] = b ? 1 : -1;
            step(1'b1, b);
            m = (n + 1) / r - 1;
            if (ok && ((n + 1) % r == 0) && m >= effn) begin
                chk(pcm_valid === 1'b1, {tag, " R2 valid at window end"}, pcm_valid, 1);
                chk(pcm_data === expect_at(n, effn, lr), {tag, " R2 sample value"},
                    pcm_data, expect_at(n, effn, lr));
            end else if (pcm_valid !== 1'b0) begin
                chk(1'b0, {tag, " R7 unexpected output"}, pcm_valid, 0);
            end
        end
        @(negedge clk);
        capture_en = 1'b0;
        pdm_valid  = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(posedge clk);
        #1;
        chk(pcm_valid === 1'b0 && pcm_data === 24'h0, "R1 reset outputs", {pcm_valid, pcm_data}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: capture with reset-held config still needs a legal rate from the start edge
        // R3: stage counts 1..5 at rate 8, pseudo-random stream
        run_case(0, 4'd1, 4'd1, 2'd0, 1, 3, 1, 200, 0, 0, "ord1");
        run_case(0, 4'd2, 4'd1, 2'd0, 2, 3, 1, 200, 0, 0, "ord2");
        run_case(0, 4'd3, 4'd1, 2'd0, 3, 3, 1, 200, 0, 0, "ord3");
        run_case(0, 4'd4, 4'd1, 2'd0, 4, 3, 1, 200, 0, 0, "ord4");
        run_case(0, 4'd5, 4'd1, 2'd0, 5, 3, 1, 200, 0, 0, "ord5");
        run_case(0, 4'd5, 4'd1, 2'd0, 5, 3, 1, 160, 3, 0, "ord5 sparse");
        // R3: illegal stage codes fall back to three stages
        run_case(0, 4'd0, 4'd1, 2'd0, 3, 3, 1, 120, 0, 0, "R3 code0");
        run_case(0, 4'd9, 4'd1, 2'd0, 3, 3, 1, 120, 0, 0, "R3 code9");
        // R4: direct-path rate codes
        run_case(0, 4'd2, 4'd2, 2'd0, 2, 4, 1, 200, 0, 0, "R4 rate16");
        run_case(0, 4'd4, 4'd3, 2'd0, 4, 5, 1, 320, 0, 0, "R4 rate32");
        run_case(0, 4'd3, 4'd0, 2'd0, 3, 3, 0, 80, 0, 0, "R4 code0 off");
        run_case(0, 4'd3, 4'd7, 2'd0, 3, 3, 0, 80, 0, 0, "R4 code7 off");
        // R5: audio-path rate codes
        run_case(1, 4'd2, 4'd0, 2'd1, 2, 6, 1, 448, 0, 0, "R5 rate64");
        run_case(1, 4'd1, 4'd9, 2'd3, 1, 8, 1, 768, 1, 0, "R5 rate256");
        run_case(1, 4'd3, 4'd1, 2'd0, 3, 6, 0, 200, 0, 0, "R5 code0 off");
        // R6: fields change mid-capture, output keeps the start configuration
        run_case(0, 4'd3, 4'd1, 2'd0, 3, 3, 1, 240, 0, 1, "R6 frozen");
        // R9: clamp and negative full scale
        run_case(0, 4'd5, 4'd6, 2'd0, 5, 8, 1, 1600, 1, 0, "R9 ones5x256");
        run_case(0, 4'd5, 4'd6, 2'd0, 5, 8, 1, 1600, 2, 0, "R9 zeros5x256");
        run_case(0, 4'd1, 4'd1, 2'd0, 1, 3, 1, 40, 1, 0, "R9 ones1x8");

        // R8: bits while capture is off produce nothing
        cnt = 0;
        for (int n = 0; n < 40; n++) begin
            step(1'b1, n[0]);
            if (pcm_valid) cnt++;
        end
        chk(cnt == 0, "R8 capture off", cnt, 0);

        // R10: valid low right after capture stops at a window end
        run_case(0, 4'd1, 4'd1, 2'd0, 1, 3, 1, 32, 0, 0, "R10 pre");
        @(posedge clk);
        #1;
        chk(pcm_valid === 1'b0, "R10 quiet after stop", pcm_valid, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule